// File: doc/BRIEF.md
# Address-Encoded SPI Master

This block is a SPI master placed behind a bus window that only carries reads. Because an access carries no write data, the operation and its operand are both encoded in the address. The block decodes the address of each access into one of several operations: 8-bit or 16-bit shifts, reads of the receive register, byte skips with a fixed MOSI level, a query of the time elapsed since the previous query, and a bit-bang chip-select write. Results come back on the upper data lines.

A shift access completes its bus cycle without waiting for the shift. The access returns the receive register as it stands and latches the transmit operand. The shift starts only once the address strobe has gone high again. Software therefore issues a shift and collects its result with the next access. Any access that arrives while a shift is pending or running is held until the engine is idle. The value it returns is then always the result of the completed shift.

Top module: `addr_spi_engine`

## Requirements
- R1: After reset, spi_cs_n is 1, spi_sclk is 0, spi_mosi is 1, busy is 0, bus_ack is 0 and bus_rdata is 0.
- R2: The address is decoded as follows. Byte address 0x4090_0000 to 0x4093_FFFF is a 16-bit shift. 0x4094_0000 to 0x4097_FFFF is a swapped 16-bit shift. 0x408A_xxxx is a command write. Within the 1 KiB windows, 0x4089_0800 is a receive read, 0x4089_0C00 a swapped receive read, 0x4089_1000 an 8-bit shift, 0x4089_1400 a swapped 8-bit shift, 0x4089_1800 a skip with MOSI 0, 0x4089_1C00 a skip with MOSI 1, and 0x4089_2000 the timer. Any other address is acknowledged with data 0 and has no effect.
- R3: Every access, meaning bus_as_n low, gets exactly one single-cycle bus_ack. The ack is given only once busy is low, so an access made during a shift returns that shift's result.
- R4: A 16-bit shift sends address bits [17:2] MSB first in 16 SCLK pulses. It returns the receive register from before the shift on bus_rdata[31:16], with zeros below. No SCLK pulse occurs until bus_as_n is high again.
- R5: An 8-bit shift sends address bits [9:2] in 8 pulses. The receive register becomes {previous low byte, received byte}.
- R6: The swapped shift and swapped receive-read operations return the receive register with its two bytes exchanged on bus_rdata[31:16].
- R7: A receive read returns the receive register on bus_rdata[31:16] and produces no SCLK pulse.
- R8: A skip clocks 8×N pulses, where N is address bits [9:2]. MOSI is held at 1 or at 0 for the whole skip, and the receive register is unchanged. With N = 0 there are no pulses.
- R9: The bus is SPI mode 0. SCLK idles low and each SCLK phase lasts HALF_DIV clocks. MOSI never changes while SCLK is high, and MISO is sampled as SCLK rises.
- R10: The timer access returns on bus_rdata[31:24] the number of TICK_DIV-clock ticks since the previous timer access, and then clears the count. The count saturates at 255.
- R11: A command write to target address bits [15:10] = 0 sets spi_cs_n to address bit 2. Writes to other targets leave spi_cs_n unchanged. spi_cs_n changes only together with an ack.
- R12: busy is high from the acknowledge of a shift or non-empty skip until its last SCLK fall, and SCLK is never high while busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_as_n | input | 1 | Address strobe, active low |
| bus_addr | input | 32 | Byte address of the access |
| bus_rdata | output | 32 | Read data, held until the next acknowledge |
| bus_ack | output | 1 | Single-cycle access completion |
| spi_sclk | output | 1 | SPI clock |
| spi_mosi | output | 1 | SPI data out |
| spi_miso | input | 1 | SPI data in |
| spi_cs_n | output | 1 | Chip select, bit-bang controlled |
| busy | output | 1 | Shift pending or running |

## Verification
Some properties hold on every cycle and are checked by assertions. MOSI stays still while SCLK is high. SCLK is only high while busy. The ack is a one-cycle pulse that rises only after an idle cycle. The chip select moves only with an acknowledge. The bench's scenarios cover what needs data and ordering: the transmitted bit order, the receive register's contents and byte order after 8- and 16-bit shifts, the stale-versus-fresh data on back-to-back accesses, skip pulse counts and MOSI level, timer values including saturation, and the decode of reserved addresses.

// File: rtl/addr_spi_pkg.sv
package addr_spi_pkg;

    localparam int BITCNT_W = 11;   // up to 255 skip bytes * 8 bits
    localparam int TIME_W   = 8;    // elapsed count on D[31:24]

    // window bases, compared on the upper address bits
    localparam logic [13:0] WIN16_PLAIN = 14'h1024;     // addr[31:18]
    localparam logic [13:0] WIN16_SWAP  = 14'h1025;
    localparam logic [15:0] WIN_CMDW    = 16'h408A;     // addr[31:16]
    localparam logic [21:0] WIN_RX      = 22'h102242;   // addr[31:10]
    localparam logic [21:0] WIN_RXS     = 22'h102243;
    localparam logic [21:0] WIN8_PLAIN  = 22'h102244;
    localparam logic [21:0] WIN8_SWAP   = 22'h102245;
    localparam logic [21:0] WIN_SKIPLO  = 22'h102246;
    localparam logic [21:0] WIN_SKIPHI  = 22'h102247;
    localparam logic [21:0] WIN_TIME    = 22'h102248;

    typedef enum logic [3:0] {
        OP_NONE, OP_X16, OP_X16S, OP_X8, OP_X8S, OP_RX, OP_RXS,
        OP_SKIPHI, OP_SKIPLO, OP_TIME, OP_CMDW
    } op_e;

    typedef struct packed {
        logic [15:0]         data;
        logic [BITCNT_W-1:0] nbits;
        logic                capture;
        logic                fill;
    } job_t;

    function automatic op_e decode_op(input logic [31:0] a);
        op_e r;
        r = OP_NONE;
        if (a[31:18] == WIN16_PLAIN)      r = OP_X16;
        else if (a[31:18] == WIN16_SWAP)  r = OP_X16S;
        else if (a[31:16] == WIN_CMDW)    r = OP_CMDW;
        else begin
            case (a[31:10])
                WIN_RX:     r = OP_RX;
                WIN_RXS:    r = OP_RXS;
                WIN8_PLAIN: r = OP_X8;
                WIN8_SWAP:  r = OP_X8S;
                WIN_SKIPLO: r = OP_SKIPLO;
                WIN_SKIPHI: r = OP_SKIPHI;
                WIN_TIME:   r = OP_TIME;
                default:    r = OP_NONE;
            endcase
        end
        return r;
    endfunction

    function automatic logic [31:0] rx_lane(input logic [15:0] rx, input logic swap);
        return swap ? {rx[7:0], rx[15:8], 16'h0000} : {rx, 16'h0000};
    endfunction

endpackage

// File: rtl/addr_spi_timer.sv
module addr_spi_timer
    import addr_spi_pkg::*;
#(
    parameter int TICK_DIV = 50
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    output logic [TIME_W-1:0] elapsed
);
    localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [PW-1:0] PRE_LAST = PW'(TICK_DIV - 1);

    logic [PW-1:0] pre;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pre     <= '0;
            elapsed <= '0;
        end else if (pre == PRE_LAST) begin
            pre <= '0;
            if (elapsed != {TIME_W{1'b1}}) elapsed <= elapsed + 1'b1;
        end else begin
            pre <= pre + 1'b1;
        end
    end
endmodule

// File: rtl/addr_spi_shift.sv
module addr_spi_shift
    import addr_spi_pkg::*;
#(
    parameter int HALF_DIV = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        go,
    input  job_t        job,
    input  logic        miso,
    output logic        sclk,
    output logic        mosi,
    output logic [15:0] rx,
    output logic        busy
);
    localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [DW-1:0] DIV_LAST = DW'(HALF_DIV - 1);

    logic [15:0]         sr;
    logic [BITCNT_W-1:0] left;
    logic [DW-1:0]       div;
    logic                fill, cap, run;

    assign mosi = sr[15];
    assign busy = run;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr   <= 16'hFFFF;
            left <= '0;
            div  <= '0;
            fill <= 1'b1;
            cap  <= 1'b0;
            run  <= 1'b0;
            sclk <= 1'b0;
            rx   <= '0;
        end else if (!run) begin
            if (go && job.nbits != '0) begin
                run  <= 1'b1;
                sr   <= job.data;
                left <= job.nbits;
                fill <= job.fill;
                cap  <= job.capture;
                div  <= '0;
                sclk <= 1'b0;
            end
        end else if (div != DIV_LAST) begin
            div <= div + 1'b1;
        end else begin
            div <= '0;
            if (!sclk) begin
                sclk <= 1'b1;
                if (cap) rx <= {rx[14:0], miso};
            end else begin
                sclk <= 1'b0;
                sr   <= {sr[14:0], fill};
                left <= left - 1'b1;
                if (left == BITCNT_W'(1)) run <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/addr_spi_bus.sv
module addr_spi_bus
    import addr_spi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              as_n,
    input  logic [31:0]       addr,
    input  logic [15:0]       rx_word,
    input  logic              eng_busy,
    input  logic [TIME_W-1:0] elapsed,
    output logic [31:0]       rdata,
    output logic              ack,
    output job_t              job,
    output logic              job_go,
    output logic              time_clr,
    output logic              cs_n,
    output logic              busy
);
    typedef enum logic [1:0] {B_IDLE, B_WAIT, B_DONE} bst_e;

    bst_e        st;
    logic [31:0] acc_addr;
    logic        pend_valid;
    logic        ready;
    op_e         op;

    assign op       = decode_op(acc_addr);
    assign ready    = (st == B_WAIT) && !pend_valid && !eng_busy;
    assign time_clr = ready && (op == OP_TIME);
    assign busy     = pend_valid | eng_busy;
    assign job_go   = pend_valid && as_n && !eng_busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= B_IDLE;
            acc_addr   <= '0;
            pend_valid <= 1'b0;
            job        <= '0;
            rdata      <= '0;
            ack        <= 1'b0;
            cs_n       <= 1'b1;
        end else begin
            ack <= 1'b0;
            if (job_go) pend_valid <= 1'b0;
            case (st)
                B_IDLE: if (!as_n) begin
                    acc_addr <= addr;
                    st       <= B_WAIT;
                end
                B_WAIT: if (ready) begin
                    ack   <= 1'b1;
                    st    <= B_DONE;
                    rdata <= '0;
                    case (op)
                        OP_X16, OP_X16S: begin
                            rdata      <= rx_lane(rx_word, op == OP_X16S);
                            job        <= '{data: acc_addr[17:2], nbits: BITCNT_W'(16),
                                            capture: 1'b1, fill: 1'b1};
                            pend_valid <= 1'b1;
                        end
                        OP_X8, OP_X8S: begin
                            rdata      <= rx_lane(rx_word, op == OP_X8S);
                            job        <= '{data: {acc_addr[9:2], 8'hFF}, nbits: BITCNT_W'(8),
                                            capture: 1'b1, fill: 1'b1};
                            pend_valid <= 1'b1;
                        end
                        OP_RX, OP_RXS:
                            rdata <= rx_lane(rx_word, op == OP_RXS);
                        OP_SKIPHI, OP_SKIPLO: begin
                            job        <= '{data: {16{op == OP_SKIPHI}},
                                            nbits: {acc_addr[9:2], 3'b000},
                                            capture: 1'b0, fill: (op == OP_SKIPHI)};
                            pend_valid <= (acc_addr[9:2] != 8'h00);
                        end
                        OP_TIME:
                            rdata <= {elapsed, {(32-TIME_W){1'b0}}};
                        OP_CMDW:
                            if (acc_addr[15:10] == 6'd0) cs_n <= acc_addr[2];
                        default: ;
                    endcase
                end
                B_DONE: if (as_n) st <= B_IDLE;
                default: st <= B_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/addr_spi_engine.sv
module addr_spi_engine
    import addr_spi_pkg::*;
#(
    parameter int HALF_DIV = 2,
    parameter int TICK_DIV = 50
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_as_n,
    input  logic [31:0] bus_addr,
    output logic [31:0] bus_rdata,
    output logic        bus_ack,
    output logic        spi_sclk,
    output logic        spi_mosi,
    input  logic        spi_miso,
    output logic        spi_cs_n,
    output logic        busy
);
    job_t              job;
    logic              job_go, time_clr, eng_busy;
    logic [15:0]       rx_word;
    logic [TIME_W-1:0] elapsed;

    addr_spi_bus u_bus (
        .clk      (clk),
        .rst      (rst),
        .as_n     (bus_as_n),
        .addr     (bus_addr),
        .rx_word  (rx_word),
        .eng_busy (eng_busy),
        .elapsed  (elapsed),
        .rdata    (bus_rdata),
        .ack      (bus_ack),
        .job      (job),
        .job_go   (job_go),
        .time_clr (time_clr),
        .cs_n     (spi_cs_n),
        .busy     (busy)
    );

    addr_spi_shift #(.HALF_DIV(HALF_DIV)) u_shift (
        .clk  (clk),
        .rst  (rst),
        .go   (job_go),
        .job  (job),
        .miso (spi_miso),
        .sclk (spi_sclk),
        .mosi (spi_mosi),
        .rx   (rx_word),
        .busy (eng_busy)
    );

    addr_spi_timer #(.TICK_DIV(TICK_DIV)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .clr     (time_clr),
        .elapsed (elapsed)
    );
endmodule

// File: rtl/addr_spi_engine_chk.sv
module addr_spi_engine_chk (
    input logic clk,
    input logic rst,
    input logic bus_ack,
    input logic spi_sclk,
    input logic spi_mosi,
    input logic spi_cs_n,
    input logic busy
);
    assert_ack_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        bus_ack |=> !bus_ack);

    assert_ack_after_idle_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_ack) |-> !$past(busy));

    assert_mosi_still_R9: assert property (@(posedge clk) disable iff (rst)
        (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));

    assert_sclk_in_busy_R12: assert property (@(posedge clk) disable iff (rst)
        spi_sclk |-> busy);

    assert_cs_with_ack_R11: assert property (@(posedge clk) disable iff (rst)
        !$stable(spi_cs_n) |-> bus_ack);
endmodule

bind addr_spi_engine addr_spi_engine_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_ack  (bus_ack),
    .spi_sclk (spi_sclk),
    .spi_mosi (spi_mosi),
    .spi_cs_n (spi_cs_n),
    .busy     (busy)
);

// File: tb/addr_spi_engine_test.sv
module addr_spi_engine_test;
    localparam int HALF_DIV = 2;
    localparam int TICK_DIV = 50;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_as_n = 1'b1;
    logic [31:0] bus_addr = '0;
    logic [31:0] bus_rdata;
    logic        bus_ack, spi_sclk, spi_mosi, spi_miso, spi_cs_n, busy;

    int compared = 0;
    int mismatched = 0;

    // SPI slave model
    logic [15:0] slave_word = 16'h0000;
    logic [15:0] slave_got = 16'h0000;
    int rises = 0;
    int ones = 0;
    int base = 0;
    logic [31:0] rel;
    assign rel = 32'(rises - base);
    assign spi_miso = slave_word[4'd15 - rel[3:0]];

    always @(posedge spi_sclk) begin
        slave_got <= {slave_got[14:0], spi_mosi};
        rises     <= rises + 1;
        ones      <= ones + int'(spi_mosi);
    end

    always #10 clk = ~clk;

    addr_spi_engine #(.HALF_DIV(HALF_DIV), .TICK_DIV(TICK_DIV)) uut (
        .clk(clk), .rst(rst), .bus_as_n(bus_as_n), .bus_addr(bus_addr),
        .bus_rdata(bus_rdata), .bus_ack(bus_ack), .spi_sclk(spi_sclk),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n), .busy(busy)
    );

    logic [15:0] exp_rx = 16'h0000;
    int rises_at_ack;
    int busy_at_ack;
    int hi_cycles;

    task automatic check(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
        compared++;
        if (got !== exp) begin
            mismatched++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic access(input logic [31:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        bus_as_n = 1'b0;
        do @(negedge clk); while (!bus_ack);
        d = bus_rdata;
        rises_at_ack = rises;
        busy_at_ack = int'(busy);
        bus_as_n = 1'b1;
    endtask

    task automatic wait_idle();
        hi_cycles = 0;
        @(negedge clk);
        while (busy) begin
            if (spi_sclk) hi_cycles++;
            @(negedge clk);
        end
        @(negedge clk);
    endtask

    function automatic logic [15:0] sw(input logic [15:0] v);
        return {v[7:0], v[15:8]};
    endfunction

    task automatic t_reset();
        check("R1", "cs_n", 32'(spi_cs_n), 32'd1);
        check("R1", "sclk", 32'(spi_sclk), 32'd0);
        check("R1", "mosi", 32'(spi_mosi), 32'd1);
        check("R1", "busy", 32'(busy), 32'd0);
        check("R1", "ack/rdata", {bus_rdata[31:1], bus_ack}, 32'd0);
    endtask

    task automatic t_x16(input logic [15:0] tx, input logic [15:0] sl, input logic swp);
        logic [31:0] d;
        int r0;
        slave_word = sl;
        base = rises;
        r0 = rises;
        access((swp ? 32'h4094_0000 : 32'h4090_0000) | {14'h0, tx, 2'b00}, d);
        check(swp ? "R6" : "R4", "x16 readback", d, {swp ? sw(exp_rx) : exp_rx, 16'h0});
        check("R4", "no pulse before strobe high", 32'(rises_at_ack - r0), 32'd0);
        check("R12", "busy at ack", 32'(busy_at_ack), 32'd1);
        wait_idle();
        check("R4", "pulses", 32'(rises - r0), 32'd16);
        check("R4", "mosi bits", 32'(slave_got), 32'(tx));
        check("R9", "sclk high cycles", 32'(hi_cycles), 32'(16 * HALF_DIV));
        check("R12", "busy cleared", 32'(busy), 32'd0);
        exp_rx = sl;
    endtask

    task automatic t_x8(input logic [7:0] tx, input logic [7:0] sl, input logic swp);
        logic [31:0] d;
        int r0;
        slave_word = {sl, 8'h00};
        base = rises;
        r0 = rises;
        access((swp ? 32'h4089_1400 : 32'h4089_1000) | {22'h0, tx, 2'b00}, d);
        check(swp ? "R6" : "R5", "x8 readback", d, {swp ? sw(exp_rx) : exp_rx, 16'h0});
        wait_idle();
        check("R5", "pulses", 32'(rises - r0), 32'd8);
        check("R5", "mosi bits", 32'(slave_got[7:0]), 32'(tx));
        exp_rx = {exp_rx[7:0], sl};
    endtask

    task automatic t_rxread();
        logic [31:0] d;
        int r0;
        r0 = rises;
        access(32'h4089_0800, d);
        check("R7", "rx read", d, {exp_rx, 16'h0});
        access(32'h4089_0C00, d);
        check("R6", "rx read swapped", d, {sw(exp_rx), 16'h0});
        repeat (4) @(negedge clk);
        check("R7", "no pulse on read", 32'(rises - r0), 32'd0);
    endtask

    task automatic t_stall();
        logic [31:0] d;
        slave_word = 16'h1357;
        base = rises;
        access(32'h4090_0000 | {14'h0, 16'h8001, 2'b00}, d);
        access(32'h4089_0800, d);   // held until the shift completes
        check("R3", "read after shift sees fresh rx", d, {16'h1357, 16'h0});
        check("R3", "ack only when idle", 32'(busy_at_ack), 32'd0);
        exp_rx = 16'h1357;
    endtask

    task automatic t_skip(input logic hi, input logic [7:0] n);
        logic [31:0] d;
        int r0, o0;
        r0 = rises;
        o0 = ones;
        access((hi ? 32'h4089_1C00 : 32'h4089_1800) | {22'h0, n, 2'b00}, d);
        wait_idle();
        repeat (4) @(negedge clk);
        check("R8", "skip pulses", 32'(rises - r0), 32'(8 * int'(n)));
        check("R8", "skip mosi level", 32'(ones - o0), hi ? 32'(8 * int'(n)) : 32'd0);
        access(32'h4089_0800, d);
        check("R8", "rx untouched by skip", d, {exp_rx, 16'h0});
    endtask

    task automatic t_cmdw();
        logic [31:0] d;
        access(32'h408A_0000 | (32'h00 << 2), d);
        check("R11", "cs low via target 0", 32'(spi_cs_n), 32'd0);
        access(32'h408A_0000 | (32'd5 << 10) | (32'h01 << 2), d);
        check("R11", "other target ignored", 32'(spi_cs_n), 32'd0);
        access(32'h408A_0000 | (32'h01 << 2), d);
        check("R11", "cs high via target 0", 32'(spi_cs_n), 32'd1);
    endtask

    task automatic t_timer();
        logic [31:0] d;
        int v;
        access(32'h4089_2000, d);
        repeat (500) @(negedge clk);
        access(32'h4089_2000, d);
        v = int'(d[31:24]);
        check("R10", "elapsed near 10 ticks", 32'((v >= 9 && v <= 11) ? 1 : 0), 32'd1);
        check("R10", "low bits zero", 32'(d[23:0]), 32'd0);
        repeat (13000) @(negedge clk);
        access(32'h4089_2000, d);
        check("R10", "saturated", 32'(d[31:24]), 32'd255);
        access(32'h4089_2000, d);
        check("R10", "cleared by read", 32'(d[31:24]), 32'd0);
    endtask

    task automatic t_unknown();
        logic [31:0] d;
        int r0;
        r0 = rises;
        access(32'h4089_0400, d);
        repeat (4) @(negedge clk);
        check("R2", "reserved data", d, 32'd0);
        check("R2", "reserved no pulse", 32'(rises - r0), 32'd0);
        check("R2", "reserved no busy", 32'(busy), 32'd0);
    endtask

    bit done = 1'b0;

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_x16(16'h1234, 16'hA55A, 1'b0);
        t_x16(16'hBEEF, 16'h0F0F, 1'b1);
        t_x8(8'hC3, 8'h96, 1'b0);
        t_x8(8'h3C, 8'h71, 1'b1);
        t_rxread();
        t_stall();
        t_skip(1'b1, 8'd3);
        t_skip(1'b0, 8'd2);
        t_skip(1'b1, 8'd0);
        t_cmdw();
        t_unknown();
        t_timer();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared + 1, mismatched + 1);
            $finish;
        end
    end
endmodule